// File: doc/BRIEF.md
# Series-Product Reciprocal Divider

This block divides one unsigned fraction by another without a digit-by-digit recurrence. When a start is accepted, a small computed table turns the leading divisor bits into a rough reciprocal. The dividend and the divisor are both scaled by that estimate. After that, each pass forms a correction factor as two minus the current denominator. The running numerator and the running denominator are multiplied by that same factor in the same cycle, using two separate multipliers.

If the scaled denominator is written as 1 - e, one pass turns it into 1 - e². The number of correct bits therefore doubles on every pass while the ratio of the two running terms stays fixed. When the denominator has converged, the numerator is the quotient. It is rounded to the output width and presented with a one-cycle `done` pulse.

The number of passes is fixed when the block is built. It is the smallest count that takes the seed's guaranteed accuracy past the fraction width. With the default 32-bit fractions and a 4-bit table index, that count is three.

Top module: `gsd_divider`

## Requirements
- R1: While reset is asserted, and after it is released with no start, `quotient` reads 0 and `done` stays low.
- R2: `done` is high for exactly one cycle. It rises on the third rising clock edge after the edge that accepts `start` (default W = 32).
- R3: Operands are W-bit fractions worth int·2^-W, and the divisor has bit W-1 set. `quotient` is unsigned, with one integer bit and W fraction bits. Its integer value lies within 1 of floor(dividend·2^W / divisor).
- R4: When dividend equals divisor, `quotient` lies within 1 of 2^W.
- R5: With the divisor exactly one half (only bit W-1 set), `quotient` lies within 1 of 2·dividend. This holds up to the all-ones dividend, which gives the largest result.
- R6: The seed table is indexed by divisor bits W-2 down to W-5. The lowest and highest divisor in each of the 16 segments meet R3.
- R7: A `start` raised while a division is in progress is ignored. The running division finishes on time with its own result, and no extra `done` follows.
- R8: `quotient` keeps its value in every cycle in which `done` is low.
- R9: A zero dividend gives a `quotient` of exactly 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a division with the present operands (sampled while idle) |
| dividend | input | W | Numerator fraction |
| divisor | input | W | Denominator fraction, bit W-1 set |
| quotient | output | W+1 | Result: 1 integer bit, W fraction bits |
| done | output | 1 | One-cycle pulse when `quotient` is updated |

## Verification
The edge that accepts `start` performs the seed scaling, and each of the three later edges performs one correction pass. The result and `done` therefore appear together just after the third edge following acceptance. The bench drives operands on falling edges. It counts falling edges after the accepting edge and requires the first high `done` at count three, with exactly one high sample in the window. It captures `quotient` in that same sample and compares it with a reference quotient computed by wide integer division. Hold and ignore checks re-sample `quotient` on falling edges during the idle cycles that follow.

// File: rtl/gsd_pkg.sv
package gsd_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } gsd_state_e;

    // Smallest number of squaring passes that takes seed_bits of accuracy to width.
    function automatic int unsigned passes_for(input int unsigned seed_bits,
                                               input int unsigned width);
        int unsigned good;
        int unsigned k;
        good = seed_bits;
        k    = 0;
        while (good < width) begin
            good = good * 2;
            k    = k + 1;
        end
        return (k == 0) ? 1 : k;
    endfunction

endpackage

// File: rtl/gsd_seed_rom.sv
// Reciprocal estimate for divisors in [0.5, 1): each segment gets the
// reciprocal of its midpoint, rounded to EST_FRAC fraction bits.
module gsd_seed_rom #(
    parameter int IDX_BITS = 4,
    parameter int EST_FRAC = 8
) (
    input  logic [IDX_BITS-1:0] idx,
    output logic [EST_FRAC:0]   est
);
    localparam int ENTRIES = 1 << IDX_BITS;

    logic [EST_FRAC:0] tbl [ENTRIES];

    for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
        // segment midpoint = (2*ENTRIES + 2*i + 1) / (4*ENTRIES)
        localparam longint unsigned MID_NUM = longint'(2 * ENTRIES + 2 * i + 1);
        localparam longint unsigned SCALED  = longint'(8 * ENTRIES) << EST_FRAC;
        localparam longint unsigned VAL     = (SCALED + MID_NUM) / (2 * MID_NUM);
        assign tbl[i] = VAL[EST_FRAC:0];
    end

    assign est = tbl[idx];
endmodule

// File: rtl/gsd_scale.sv
// Fixed-point product: both operands and the result carry FRAC fraction bits.
module gsd_scale #(
    parameter int IW   = 42,
    parameter int FRAC = 40
) (
    input  logic [IW-1:0] x,
    input  logic [IW-1:0] y,
    output logic [IW-1:0] p
);
    assign p = IW'(({{IW{1'b0}}, x} * {{IW{1'b0}}, y}) >> FRAC);
endmodule

// File: rtl/gsd_divider.sv
module gsd_divider
    import gsd_pkg::*;
#(
    parameter int W        = 32,
    parameter int IDX_BITS = 4,
    parameter int EST_FRAC = 8,
    parameter int GUARD    = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic [W:0]   quotient,
    output logic         done
);
    localparam int F      = W + GUARD;     // internal fraction bits
    localparam int IW     = F + 2;         // two integer bits
    localparam int QW     = W + 1;
    localparam int PASSES = passes_for(IDX_BITS, W);
    localparam int CW     = $clog2(PASSES + 1);
    localparam logic [IW-1:0] TWO      = IW'(1) << (F + 1);
    localparam logic [IW-1:0] HALF_ULP = IW'(1) << (GUARD - 1);

    typedef struct packed {
        gsd_state_e     st;
        logic [CW-1:0]  cnt;
        logic [IW-1:0]  num;
        logic [IW-1:0]  den;
        logic [QW-1:0]  quo;
        logic           done;
    } regs_t;

    regs_t r_d, r_q;

    logic [EST_FRAC:0] seed;
    logic [IW-1:0]     seed_ext, dvd_ext, dvs_ext, factor;
    logic [IW-1:0]     mx_num, mx_den, my_fac;
    logic [IW-1:0]     prod_num, prod_den;
    logic [QW-1:0]     rounded;

    gsd_seed_rom #(
        .IDX_BITS (IDX_BITS),
        .EST_FRAC (EST_FRAC)
    ) u_seed (
        .idx (divisor[W-2 -: IDX_BITS]),
        .est (seed)
    );

    assign seed_ext = IW'(seed) << (F - EST_FRAC);
    assign dvd_ext  = IW'(dividend) << GUARD;
    assign dvs_ext  = IW'(divisor) << GUARD;
    assign factor   = TWO - r_q.den;   // complement about two

    // Operand selection: seed scaling while idle, correction passes while running.
    always_comb begin
        if (r_q.st == ST_IDLE) begin
            mx_num = dvd_ext;
            mx_den = dvs_ext;
            my_fac = seed_ext;
        end else begin
            mx_num = r_q.num;
            mx_den = r_q.den;
            my_fac = factor;
        end
    end

    // Numerator and denominator are scaled by the same factor in parallel.
    gsd_scale #(.IW(IW), .FRAC(F)) u_mul_num (
        .x (mx_num),
        .y (my_fac),
        .p (prod_num)
    );

    gsd_scale #(.IW(IW), .FRAC(F)) u_mul_den (
        .x (mx_den),
        .y (my_fac),
        .p (prod_den)
    );

    assign rounded = QW'((prod_num + HALF_ULP) >> GUARD);

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        if (r_q.st == ST_IDLE) begin
            if (start) begin
                r_d.st  = ST_RUN;
                r_d.cnt = '0;
                r_d.num = prod_num;
                r_d.den = prod_den;
            end
        end else begin
            r_d.num = prod_num;
            r_d.den = prod_den;
            r_d.cnt = r_q.cnt + CW'(1);
            if (r_q.cnt == CW'(PASSES - 1)) begin
                r_d.st   = ST_IDLE;
                r_d.quo  = rounded;
                r_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign quotient = r_q.quo;
    assign done     = r_q.done;
endmodule

// File: rtl/gsd_divider_chk.sv
module gsd_divider_chk #(
    parameter int W      = 32,
    parameter int PASSES = 3
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic [W-1:0] dividend,
    input logic [W:0]   quotient,
    input logic         done
);
    localparam int CW = $clog2(PASSES + 2);

    logic          busy_m;
    logic [CW-1:0] age;
    logic          zero_m;

    // Independent model of when a division is in flight.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_m <= 1'b0;
            age    <= '0;
            zero_m <= 1'b0;
        end else if (start && (!busy_m || done)) begin
            busy_m <= 1'b1;
            age    <= '0;
            zero_m <= (dividend == '0);
        end else if (done) begin
            busy_m <= 1'b0;
        end else if (busy_m && (age < CW'(PASSES))) begin
            age <= age + CW'(1);
        end
    end

    // R2: result arrives exactly PASSES edges after acceptance
    a_r2_done_latency: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (busy_m && age == CW'(PASSES)));

    // R2: done is a single-cycle pulse
    a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: quotient only moves together with done
    a_r8_quotient_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (quotient != $past(quotient)) |-> done);

    // R9: zero dividend yields zero quotient
    a_r9_zero_result: assert property (@(posedge clk) disable iff (!rst_n)
        (done && zero_m) |-> (quotient == '0));

    // R7: no completion without a division in flight
    a_r7_no_stray_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy_m);
endmodule

bind gsd_divider gsd_divider_chk #(
    .W      (W),
    .PASSES (PASSES)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .dividend (dividend),
    .quotient (quotient),
    .done     (done)
);

// File: tb/tb_gsd_divider.sv
module tb_gsd_divider;
    localparam int W   = 32;
    localparam int LAT = 3;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         start;
    logic [W-1:0] dividend;
    logic [W-1:0] divisor;
    logic [W:0]   quotient;
    logic         done;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    gsd_divider dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .dividend (dividend),
        .divisor  (divisor),
        .quotient (quotient),
        .done     (done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic longint ref_quot(input logic [W-1:0] a, input logic [W-1:0] b);
        logic [95:0] num;
        num = {64'b0, a} << W;
        return longint'(num / {64'b0, b});
    endfunction

    // Issue one division and check its timing and value.
    task automatic run_div(input logic [W-1:0] a, input logic [W-1:0] b, input string req);
        longint exp_q;
        longint got;
        int     first;
        int     highs;
        exp_q = ref_quot(a, b);
        @(negedge clk);
        dividend = a;
        divisor  = b;
        start    = 1'b1;
        @(negedge clk);           // accepting edge has passed
        start = 1'b0;
        first = 0;
        highs = 0;
        got   = 0;
        for (int k = 1; k <= LAT + 2; k++) begin
            @(negedge clk);
            if (done) begin
                highs++;
                if (first == 0) begin
                    first = k;
                    got   = longint'(quotient);
                end
            end
        end
        check(first == LAT, "R2", "done latency", first, LAT);
        check(highs == 1, "R2", "done width", highs, 1);
        check((got - exp_q <= 1) && (exp_q - got <= 1), req, "quotient", got, exp_q);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL R2 watchdog: actual %0d cycles expected completion", 100000);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic [W:0]   held;
        longint       e1;
        longint       got;
        int           first;
        int           highs;

        void'($urandom(32'd20240611));
        rst_n    = 1'b0;
        start    = 1'b0;
        dividend = '0;
        divisor  = {1'b1, {(W-1){1'b0}}};

        repeat (3) @(negedge clk);
        check(quotient == '0, "R1", "quotient in reset", longint'(quotient), 0);
        check(done == 1'b0, "R1", "done in reset", longint'(done), 0);
        rst_n = 1'b1;
        highs = 0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (done) highs++;
        end
        check(highs == 0, "R1", "done without start", highs, 0);
        check(quotient == '0, "R1", "quotient after reset", longint'(quotient), 0);

        // R4: equal operands
        run_div(32'h8000_0000, 32'h8000_0000, "R4");
        run_div(32'hFFFF_FFFF, 32'hFFFF_FFFF, "R4");
        run_div(32'hC000_0001, 32'hC000_0001, "R4");

        // R5: divisor of one half, including the largest quotient
        run_div(32'hFFFF_FFFF, 32'h8000_0000, "R5");
        run_div(32'h1234_5678, 32'h8000_0000, "R5");
        run_div(32'h0000_0001, 32'h8000_0000, "R5");

        // R9: zero dividend must give exactly zero
        run_div(32'h0, 32'hA5A5_A5A5, "R9");
        check(quotient == '0, "R9", "exact zero", longint'(quotient), 0);

        // R6: both ends of every seed segment
        for (int i = 0; i < 16; i++) begin
            b = 32'h8000_0000 | (32'(i) << 27);
            run_div($urandom(), b, "R6");
            run_div($urandom(), b | 32'h07FF_FFFF, "R6");
        end

        // R7: second start during a run is ignored
        a = 32'h9ABC_DEF0;
        b = 32'hB000_0003;
        e1 = ref_quot(a, b);
        @(negedge clk);
        dividend = a;
        divisor  = b;
        start    = 1'b1;
        @(negedge clk);
        dividend = 32'h1111_1111;
        divisor  = 32'hF000_0000;   // stays asserted across one running edge
        @(negedge clk);
        start = 1'b0;
        first = 0;
        highs = 0;
        got   = 0;
        for (int k = 2; k <= LAT + 5; k++) begin
            @(negedge clk);
            if (done) begin
                highs++;
                if (first == 0) begin
                    first = k;
                    got   = longint'(quotient);
                end
            end
        end
        check(first == LAT, "R7", "latency with extra start", first, LAT);
        check(highs == 1, "R7", "no second completion", highs, 1);
        check((got - e1 <= 1) && (e1 - got <= 1), "R7", "first operands kept", got, e1);

        // R8: quotient held while idle
        held = quotient;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            check(quotient == held, "R8", "hold while idle", longint'(quotient), longint'(held));
        end

        // R3: random operands
        for (int n = 0; n < 150; n++) begin
            a = $urandom();
            b = $urandom() | 32'h8000_0000;
            run_div(a, b, "R3");
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule